// File: doc/BRIEF.md
# Temporal SIMD Instruction Sequencer

The sequencer holds a buffer of wide instruction words and sends one word per clock to four execution slices. A word is not spent in one cycle. Each stored word carries a repeat count and stays on the issue outputs for that many unstalled cycles. During those cycles an element index runs through the 32 elements of the vector registers in order. Vector work is therefore spread over time rather than over parallel lanes. A word that holds eight slice fields drives as many as 32 element operations in every slice.

The host fills the buffer through a valid/ready write port while the sequencer is idle. A start pulse with an entry address begins execution. Words are then issued in address order, and the address wraps at the end of the buffer. A word whose control opcode is nonzero is a halt: it stops the run and produces a one-cycle done pulse. A stall input from the load-store side freezes the sequence for as long as it is high.

A staggered mode is available. In this mode slice s shows the fields of the word that slice 0 ran s words earlier, at the same element index. Slices can then share one instruction stream, each lagging its neighbour by one word, which is 32 cycles at full repeat. Decoding the slice fields is left to the slices.

Top module: `tsq_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `iss_valid` are low, `elem_idx` is 0 and `ld_ready` is high. A host word is written at `ld_addr` on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is high only when the sequencer is idle and `start` is low.
- R2: A `start` pulse seen while idle begins the run at `start_addr`. In the next cycle `busy` is high, and that word is on the outputs with `elem_idx` 0.
- R3: A word is nine fields of FIELD_W (8) bits. Field 2s is the ALU field of slice s and field 2s+1 is its LSU field, for s from 0 to 3. Field 8, the top one, is control: bits [4:0] hold the repeat count minus one, and bits [7:5] hold the opcode.
- R4: A word with repeat field r is issued in exactly r+1 unstalled cycles. The run then moves to the next address, and address 511 is followed by address 0. Issue outputs are never valid when no word is due.
- R5: Within a word, `elem_idx` starts at 0 and rises by one in each unstalled issue cycle. It is the only way elements are stepped: there is no element addressing.
- R6: While `stall` is high, `iss_valid` is all low and `elem_idx` and the address hold. Issue resumes at the same element when `stall` drops.
- R7: A word with a nonzero opcode is never issued. On its first unstalled cycle `done` is high for one cycle, and `busy` is low in the next cycle.
- R8: While busy, `ld_ready` is low and host writes are refused. The buffer contents are left unchanged.
- R9: When not staggered, every slice is valid in each issue cycle, and each carries its own fields of the same word.
- R10: `stagger` is sampled at start. When it is set, slice s carries its fields from the word issued s words before the current one, at the current `elem_idx`. Slice s is valid only once s words have completed since the start. The history is cleared at each start.
- R11: A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Host write request |
| ld_ready | output | 1 | Buffer can accept a host write |
| ld_addr | input | 9 | Host write address |
| ld_data | input | 72 | Host write word |
| start | input | 1 | Begin a run when idle |
| start_addr | input | 9 | Entry address for the run |
| stagger | input | 1 | Staggered slice mode, sampled at start |
| stall | input | 1 | Freeze issue from the load-store side |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a halt word is reached |
| iss_valid | output | 4 | Per-slice issue valid |
| iss_alu | output | 32 | Per-slice ALU fields, slice s at bits [8s+7:8s] |
| iss_lsu | output | 32 | Per-slice LSU fields, slice s at bits [8s+7:8s] |
| elem_idx | output | 5 | Current vector element index |

## Verification
The main function runs a program with repeat counts of 3, 1 and 32 in a row. This shows whether the element counter wraps at the stored count or drifts by one, and whether the length of each word in the cycle count is right. The same program is run again under a stall every second or third cycle. That run separates holding the element from advancing it, and also checks that a stall on the halt word delays `done`. The staggered mode is run twice in succession, with and without stalls. A lag history that is not cleared at start would show up as early valid slices in the second run. Further runs cover a program that wraps past the last address, a halt as the very first word, and a refused host write plus a second start issued mid-run, which a later rerun exposes if the stored word changed.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Field slot of a slice's arithmetic sub-instruction inside a word.
  function automatic int alu_slot(input int s);
    return 2 * s;
  endfunction

  // Field slot of a slice's load-store sub-instruction inside a word.
  function automatic int lsu_slot(input int s);
    return 2 * s + 1;
  endfunction

endpackage

// File: rtl/tsq_buf.sv
module tsq_buf #(
  parameter int DEPTH  = 512,
  parameter int WORD_W = 72,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  // One write port, one registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int EW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          stall,
  input  logic [EW-1:0] rep,
  input  logic          halt,
  output logic          busy,
  output logic          done,
  output logic          issue,
  output logic          adv,
  output logic          start_acc,
  output logic [AW-1:0] rd_addr,
  output logic [EW-1:0] elem
);

  seq_state_e    st;
  logic [AW-1:0] pc, pc_inc;
  logic [EW-1:0] elem_q;
  logic          run, last;

  assign run       = (st == SEQ_RUN);
  assign start_acc = !run && start;
  assign last      = (elem_q == rep);
  assign issue     = run && !stall && !halt;
  assign adv       = issue && last;
  assign done      = run && !stall && halt;
  assign pc_inc    = (pc == AW'(DEPTH - 1)) ? '0 : pc + 1'b1;
  // The read address runs one step ahead so the next word lands without a bubble.
  assign rd_addr   = run ? (adv ? pc_inc : pc) : start_addr;
  assign busy      = run;
  assign elem      = elem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SEQ_IDLE;
      pc     <= '0;
      elem_q <= '0;
    end else if (!run) begin
      if (start) begin
        st     <= SEQ_RUN;
        pc     <= start_addr;
        elem_q <= '0;
      end
    end else if (done) begin
      st     <= SEQ_IDLE;
      elem_q <= '0;
    end else if (issue) begin
      if (last) begin
        elem_q <= '0;
        pc     <= pc_inc;
      end else begin
        elem_q <= elem_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tsq_lag.sv
module tsq_lag #(
  parameter int LAG = 1,
  parameter int W   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dvalid
);

  logic [W-1:0]   pipe [LAG];
  logic [LAG-1:0] vld;

  // Word-granular history: shifts once per completed word.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < LAG; i++) pipe[i] <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (adv) begin
      pipe[0] <= din;
      vld[0]  <= 1'b1;
      for (int i = 1; i < LAG; i++) begin
        pipe[i] <= pipe[i-1];
        vld[i]  <= vld[i-1];
      end
    end
  end

  assign dout   = pipe[LAG-1];
  assign dvalid = vld[LAG-1];

endmodule

// File: rtl/tsq_sequencer.sv
module tsq_sequencer
  import tsq_pkg::*;
#(
  parameter  int NSLICE  = 4,
  parameter  int FIELD_W = 8,
  parameter  int DEPTH   = 512,
  parameter  int VLEN    = 32,
  localparam int NFIELD  = 2 * NSLICE + 1,
  localparam int WORD_W  = NFIELD * FIELD_W,
  localparam int AW      = $clog2(DEPTH),
  localparam int EW      = $clog2(VLEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  output logic                      ld_ready,
  input  logic [AW-1:0]             ld_addr,
  input  logic [WORD_W-1:0]         ld_data,
  input  logic                      start,
  input  logic [AW-1:0]             start_addr,
  input  logic                      stagger,
  input  logic                      stall,
  output logic                      busy,
  output logic                      done,
  output logic [NSLICE-1:0]         iss_valid,
  output logic [NSLICE*FIELD_W-1:0] iss_alu,
  output logic [NSLICE*FIELD_W-1:0] iss_lsu,
  output logic [EW-1:0]             elem_idx
);

  logic [WORD_W-1:0]  cur;
  logic [FIELD_W-1:0] ctrl_f;
  logic [EW-1:0]      rep;
  logic               halt;
  logic               issue, adv, start_acc;
  logic [AW-1:0]      rd_addr;
  logic               mode_q;

  assign ctrl_f   = cur[(NFIELD-1)*FIELD_W +: FIELD_W];
  assign rep      = ctrl_f[EW-1:0];
  assign halt     = |ctrl_f[FIELD_W-1:EW];
  assign ld_ready = !busy && !start;

  tsq_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (ld_valid && ld_ready),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (rd_addr),
    .rdata (cur)
  );

  tsq_ctrl #(.DEPTH(DEPTH), .AW(AW), .EW(EW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .stall      (stall),
    .rep        (rep),
    .halt       (halt),
    .busy       (busy),
    .done       (done),
    .issue      (issue),
    .adv        (adv),
    .start_acc  (start_acc),
    .rd_addr    (rd_addr),
    .elem       (elem_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= 1'b0;
    else if (start_acc) mode_q <= stagger;
  end

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [FIELD_W-1:0] alu_c, lsu_c;
    assign alu_c = cur[alu_slot(s)*FIELD_W +: FIELD_W];
    assign lsu_c = cur[lsu_slot(s)*FIELD_W +: FIELD_W];

    if (s == 0) begin : g_lead
      assign iss_alu[s*FIELD_W +: FIELD_W] = alu_c;
      assign iss_lsu[s*FIELD_W +: FIELD_W] = lsu_c;
      assign iss_valid[s]                  = issue;
    end else begin : g_lagged
      logic [2*FIELD_W-1:0] lag_q;
      logic                 lag_v;
      tsq_lag #(.LAG(s), .W(2*FIELD_W)) u_lag (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_acc),
        .adv    (adv),
        .din    ({lsu_c, alu_c}),
        .dout   (lag_q),
        .dvalid (lag_v)
      );
      assign iss_alu[s*FIELD_W +: FIELD_W] = mode_q ? lag_q[FIELD_W-1:0] : alu_c;
      assign iss_lsu[s*FIELD_W +: FIELD_W] = mode_q ? lag_q[2*FIELD_W-1:FIELD_W] : lsu_c;
      assign iss_valid[s]                  = issue && (!mode_q || lag_v);
    end
  end

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int NSLICE = 4,
  parameter int EW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ready,
  input logic              start,
  input logic              stall,
  input logic              busy,
  input logic              done,
  input logic [NSLICE-1:0] iss_valid,
  input logic [EW-1:0]     elem_idx
);

  // R8: no host write can be accepted during a run
  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);

  // R2: start from idle enters the run at element 0
  a_r2_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && elem_idx == '0));

  // R6: stall silences every slice
  a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (iss_valid == '0));

  // R6: stall freezes the element index
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stall) |=> (busy && $stable(elem_idx)));

  // R5: element index steps by one or restarts at zero
  a_r5_elem_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stall && !done) |=>
      ((elem_idx == EW'($past(elem_idx) + 1'b1)) || (elem_idx == '0)));

  // R7: halt cycle issues nothing and leaves idle next
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && iss_valid == '0));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10: lagging slices only become valid after their leaders
  for (genvar k = 1; k < NSLICE; k++) begin : g_prefix
    a_r10_valid_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k] |-> iss_valid[k-1]);
  end

endmodule

bind tsq_sequencer tsq_checker #(.NSLICE(NSLICE), .EW(EW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_ready  (ld_ready),
  .start     (start),
  .stall     (stall),
  .busy      (busy),
  .done      (done),
  .iss_valid (iss_valid),
  .elem_idx  (elem_idx)
);

// File: tb/sim_tsq_sequencer.sv
`timescale 1ns/1ps
module sim_tsq_sequencer;

  localparam int NS = 4;
  localparam int FW = 8;
  localparam int WW = 72;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [8:0]    ld_addr = '0;
  logic [WW-1:0] ld_data = '0;
  logic          start = 1'b0;
  logic [8:0]    start_addr = '0;
  logic          stagger = 1'b0;
  logic          stall = 1'b0;
  logic          busy, done;
  logic [NS-1:0] iss_valid;
  logic [31:0]   iss_alu, iss_lsu;
  logic [4:0]    elem_idx;

  tsq_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .start(start), .start_addr(start_addr),
    .stagger(stagger), .stall(stall), .busy(busy), .done(done),
    .iss_valid(iss_valid), .iss_alu(iss_alu), .iss_lsu(iss_lsu), .elem_idx(elem_idx)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [3:0]  vm;
    logic [31:0] alu;
    logic [31:0] lsu;
    logic [4:0]  el;
    string       rq;
  } exp_t;

  exp_t          sb[$];
  logic [WW-1:0] img [512];

  task automatic check(input bit ok, input string rq, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R3 layout: fields 0..7 slice fields, field 8 control {opcode[2:0], repeat-1[4:0]}
  function automatic logic [WW-1:0] mkword(input int a, input int rep, input int op);
    logic [WW-1:0] w;
    for (int i = 0; i < 8; i++) w[i*8 +: 8] = 8'(a * 11 + i * 29 + 1);
    w[71:64] = {3'(op), 5'(rep)};
    return w;
  endfunction

  task automatic load(input int a, input logic [WW-1:0] w);
    ld_valid = 1'b1;
    ld_addr  = 9'(a);
    ld_data  = w;
    tick();
    ld_valid = 1'b0;
    img[a]   = w;
  endtask

  // Driver: push the expected issue stream of a run into the scoreboard.
  task automatic expect_run(input int a, input bit stg, input string rq);
    logic [WW-1:0] h [4];
    int nw = 0;
    int pc = a;
    for (int guard = 0; guard < 600; guard++) begin
      logic [WW-1:0] w;
      w = img[pc];
      if (w[71:69] != 3'd0) break;
      for (int e = 0; e <= int'(w[68:64]); e++) begin
        exp_t it;
        it.vm = '0; it.alu = '0; it.lsu = '0; it.el = 5'(e); it.rq = rq;
        for (int s = 0; s < NS; s++) begin
          logic [WW-1:0] src;
          bit v;
          if (!stg || s == 0) begin v = 1'b1; src = w; end
          else begin v = (nw >= s); src = h[s]; end
          if (v) begin
            it.vm[s] = 1'b1;
            it.alu[s*8 +: 8] = src[(2*s)*8 +: 8];
            it.lsu[s*8 +: 8] = src[(2*s+1)*8 +: 8];
          end
        end
        sb.push_back(it);
      end
      h[3] = h[2]; h[2] = h[1]; h[1] = w;
      nw++;
      pc = (pc + 1) % 512;
    end
  endtask

  // Monitor: compare each issuing cycle against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && iss_valid != '0) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4", iss_valid, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(iss_valid == e.vm, e.rq, iss_valid, e.vm);
        check(elem_idx == e.el, "R5", elem_idx, e.el);
        for (int s = 0; s < NS; s++) begin
          if (e.vm[s]) begin
            check(iss_alu[s*8 +: 8] == e.alu[s*8 +: 8], "R3", iss_alu[s*8 +: 8], e.alu[s*8 +: 8]);
            check(iss_lsu[s*8 +: 8] == e.lsu[s*8 +: 8], "R3", iss_lsu[s*8 +: 8], e.lsu[s*8 +: 8]);
          end
        end
      end
    end
  end

  task automatic run_prog(input int a, input bit stg, input int stall_every,
                          input int poke_at, input int exp_issue, input string rq);
    int n = 0;
    int ns = 0;
    bit prev_st = 1'b0;
    logic [4:0] prev_el = '0;
    expect_run(a, stg, rq);
    start_addr = 9'(a);
    stagger    = stg;
    start      = 1'b1;
    tick();
    start      = 1'b0;
    while (n < 3000) begin
      @(negedge clk);
      n++;
      if (n == 1) check(busy === 1'b1, "R2", busy, 1);
      if (prev_st) check(elem_idx == prev_el, "R6", elem_idx, prev_el);
      if (stall) check(iss_valid == '0, "R6", iss_valid, 0);
      if (poke_at == n) check(ld_ready == 1'b0, "R8", ld_ready, 0);
      if (done) break;
      if (stall) ns++;
      prev_st = stall;
      prev_el = elem_idx;
      tick();
      stall = (stall_every > 0) && ((n % stall_every) == 0);
      // R11 / R8: during the run, pulse a second start and a host write
      start      = (poke_at == n + 1);
      ld_valid   = (poke_at == n + 1);
      start_addr = (poke_at == n + 1) ? 9'd40 : start_addr;
      ld_addr    = 9'd12;
      ld_data    = '1;
    end
    stall = 1'b0; start = 1'b0; ld_valid = 1'b0;
    check(done === 1'b1, "R7", done, 1);
    check(n == exp_issue + ns + 1, "R4", n, exp_issue + ns + 1);
    if (poke_at > 0) check(n == exp_issue + ns + 1, "R11", n, exp_issue + ns + 1);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R7", {busy, done}, 0);
    check(sb.size() == 0, rq, sb.size(), 0);
    tick();
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 0);
    check(iss_valid == '0, "R1", iss_valid, 0);
    check(elem_idx == '0, "R1", elem_idx, 0);
    check(ld_ready == 1'b1, "R1", ld_ready, 1);
    tick();

    // Program: repeats 3, 1, 32, then a halt (opcode 4)
    load(10, mkword(10, 2, 0));
    load(11, mkword(11, 0, 0));
    load(12, mkword(12, 31, 0));
    load(13, mkword(13, 0, 4));

    run_prog(10, 1'b0, 0, 0, 36, "R9");   // R9 plain run
    run_prog(10, 1'b0, 3, 0, 36, "R9");   // R6 periodic stall
    run_prog(10, 1'b0, 0, 6, 36, "R9");   // R8, R11 poke mid-run
    run_prog(10, 1'b0, 0, 0, 36, "R8");   // R8 word 12 must be unchanged
    run_prog(10, 1'b1, 0, 0, 36, "R10");  // R10 staggered
    run_prog(10, 1'b1, 2, 0, 36, "R10");  // R10 history cleared, with stalls

    // R4 wrap past the last address; halt with opcode 1 (R7)
    load(510, mkword(510, 1, 0));
    load(511, mkword(511, 0, 0));
    load(0,   mkword(0, 0, 0));
    load(1,   mkword(1, 0, 1));
    run_prog(510, 1'b0, 0, 0, 4, "R4");

    // R7 halt as first word, opcode 2
    load(20, mkword(20, 5, 2));
    run_prog(20, 1'b0, 0, 0, 0, "R7");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule